// File: doc/BRIEF.md
# Packet Buffer Framing Builder

This block turns a frame into the word layout that a page-based Ethernet packet buffer stores, and turns that layout back into a frame. It stands between a byte-oriented data path and a 16-bit buffer memory. Each access goes through a byte pointer that starts at offset 0 for every packet and moves up by 2 after each word. Bytes are packed little-endian: the lower-addressed byte sits in bits 7:0 of a word.

On the transmit side the block takes a destination address, a source address, a type value and a payload length, then pulls payload bytes from a valid/ready stream. It writes the buffer image in this order: a zero status word, a byte-count word, the header words, the payload words, and a closing word. The closing word carries an odd-length marker. On the receive side it reads an image back from offset 0. It checks the status word for error bits, recovers the frame length from the count and the closing word, and streams the frame bytes out. In every case it ends with a single completion pulse, and the surrounding logic uses that pulse to release the packet.

Top module: `pkt_frame_builder`

## Requirements
- R1: After `tx_start` in idle, the first write goes to offset 0 with data 0x0000, and each following write goes to the previous offset plus 2.
- R2: The write at offset 2 holds the byte count: (14 + payload length) rounded up to even, plus 6.
- R3: Offsets 4 to 16 hold the header. Destination bytes come first, then source bytes, each in transmission order with the earlier byte in bits 7:0. The type field is stored in network order, so offset 16 holds {type[7:0], type[15:8]}.
- R4: Payload bytes start at offset 18 and are packed two per word, with the earlier byte in bits 7:0. A source that pauses `tx_byte_valid` does not change the words written.
- R5: With an odd payload length, the last word is {0x20, final byte}. With an even length, a 0x0000 word follows the payload. `tx_done` pulses together with that last write.
- R6: `tx_start` while `tx_busy` is high is ignored, and the write sequence in progress is unchanged.
- R7: `tx_byte_ready` is high only while payload bytes are being taken; it is low during the status, count and header writes.
- R8: A receive reads from offset 0 upward in steps of 2. The byte count is bits 10:0 of the word at offset 2; the upper bits are ignored. (count - 6)/2 data words follow, delivered low byte first.
- R9: After the data words comes a closing word. If its bit 13 (0x20 in its high byte) is set, its low byte is delivered as one more frame byte and `rx_len` = count - 5. Otherwise nothing more is delivered and `rx_len` = count - 6.
- R10: A status word with any bit of ERR_MASK set (default 0xAC00) ends the receive with `rx_err` = 1, `rx_len` = 0 and no bytes delivered. Status bits outside the mask are ignored.
- R11: A byte count below 6 ends the receive with `rx_err` = 1, `rx_len` = 0 and no bytes delivered.
- R12: Each receive, good or bad, produces exactly one one-cycle `rx_done` pulse.
- R13: After reset nothing is written or read, both sides are idle, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Begin building a packet image |
| tx_dst | input | 48 | Destination address, first byte in bits 47:40 |
| tx_src | input | 48 | Source address, first byte in bits 47:40 |
| tx_type | input | 16 | Type field value |
| tx_len | input | LEN_W | Payload length in bytes |
| tx_byte | input | 8 | Payload byte |
| tx_byte_valid | input | 1 | Payload byte present |
| tx_byte_ready | output | 1 | Payload byte accepted this cycle when valid |
| tx_busy | output | 1 | Transmit build in progress |
| tx_done | output | 1 | Pulse with the final buffer write |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer byte offset of the write |
| wr_data | output | 16 | Buffer write word |
| rx_start | input | 1 | Begin parsing a stored image |
| rx_busy | output | 1 | Parse in progress |
| rd_en | output | 1 | Buffer read strobe |
| rd_addr | output | ADDR_W | Buffer byte offset of the read |
| rd_data | input | 16 | Read word, valid one cycle after `rd_en` |
| rx_byte | output | 8 | Delivered frame byte |
| rx_byte_valid | output | 1 | `rx_byte` holds a frame byte |
| rx_done | output | 1 | Parse complete; release the packet |
| rx_err | output | 1 | Parse ended on an error |
| rx_len | output | 11 | Recovered frame length |

## Verification
The assertions check several rules on every cycle: the zero status word at offset 0, even buffer offsets, the pairing of `tx_done` with a write, the readiness window, the first read at offset 0 after a start, the single-cycle completion pulse, and that no byte is delivered together with an error completion. Only the bench scenarios can show the values in the image. These are the count rounding, the header byte order, the payload packing under stalls, and the odd and even closing words. The same holds for the receive side: the recovered bytes and length with and without the odd marker, masked and unmasked status bits, and the short-count error.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    localparam int WORD_W     = 16;
    localparam int HDR_BYTES  = 14;
    localparam int HDR_WORDS  = 7;
    localparam int OVERHEAD   = 6;
    localparam int CNT_W      = 11;
    localparam logic [7:0] ODD_MARK = 8'h20;
    localparam int ODD_BIT    = 13;

    typedef enum logic [2:0] {
        TX_IDLE, TX_STAT, TX_CNT, TX_HDR, TX_PAY, TX_TAIL
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_REQ, RX_WAIT, RX_HI
    } rx_state_e;

    typedef enum logic [1:0] {
        PH_STAT, PH_CNT, PH_DATA, PH_CTRL
    } rx_phase_e;

    typedef struct packed {
        logic [47:0] dst;
        logic [47:0] src;
        logic [15:0] etype;
    } hdr_t;

    // Header word idx: byte 2*idx in the low half, byte 2*idx+1 in the high half
    function automatic logic [WORD_W-1:0] hdr_word(hdr_t h, logic [2:0] idx);
        logic [111:0] flat;
        int           sh;
        logic [7:0]   lo;
        logic [7:0]   hi;
        flat = h;
        sh   = 104 - 16 * int'(idx);
        lo   = 8'(flat >> sh);
        hi   = 8'(flat >> (sh - 8));
        return {hi, lo};
    endfunction
endpackage

// File: rtl/pfb_tx_pack.sv
module pfb_tx_pack
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  hdr_t              hdr_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [7:0]        byte_in,
    input  logic              byte_valid,
    output logic              byte_ready,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    tx_state_e         state;
    hdr_t              hdr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  remain;
    logic [2:0]        hidx;
    logic [7:0]        lo_q;
    logic              have_lo;
    logic [ADDR_W-1:0] ptr;

    logic              hs;
    logic              wr_go;
    logic              fin;
    logic [WORD_W-1:0] wr_val;
    logic [LEN_W:0]    frame_even;
    logic [WORD_W-1:0] count_word;

    always_comb begin
        frame_even    = (LEN_W+1)'(HDR_BYTES) + {1'b0, len_q} + (LEN_W+1)'(1);
        frame_even[0] = 1'b0;
        count_word    = WORD_W'(frame_even) + WORD_W'(OVERHEAD);
    end

    assign byte_ready = (state == TX_PAY);
    assign busy       = (state != TX_IDLE);
    assign hs         = byte_ready && byte_valid;

    always_comb begin
        wr_go  = 1'b0;
        fin    = 1'b0;
        wr_val = '0;
        case (state)
            TX_STAT: wr_go = 1'b1;
            TX_CNT: begin
                wr_go  = 1'b1;
                wr_val = count_word;
            end
            TX_HDR: begin
                wr_go  = 1'b1;
                wr_val = hdr_word(hdr_q, hidx);
            end
            TX_PAY: begin
                if (hs && have_lo) begin
                    wr_go  = 1'b1;
                    wr_val = {byte_in, lo_q};
                end else if (hs && remain == LEN_W'(1)) begin
                    wr_go  = 1'b1;
                    wr_val = {ODD_MARK, byte_in};
                    fin    = 1'b1;
                end
            end
            TX_TAIL: begin
                wr_go = 1'b1;
                fin   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            hdr_q   <= '0;
            len_q   <= '0;
            remain  <= '0;
            hidx    <= '0;
            lo_q    <= '0;
            have_lo <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            done    <= 1'b0;
        end else begin
            wr_en <= wr_go;
            done  <= fin;
            if (wr_go) begin
                wr_addr <= ptr;
                wr_data <= wr_val;
                ptr     <= ptr + ADDR_W'(2);
            end
            case (state)
                TX_IDLE: if (start) begin
                    hdr_q   <= hdr_in;
                    len_q   <= len_in;
                    remain  <= len_in;
                    hidx    <= '0;
                    have_lo <= 1'b0;
                    ptr     <= '0;
                    state   <= TX_STAT;
                end
                TX_STAT: state <= TX_CNT;
                TX_CNT:  state <= TX_HDR;
                TX_HDR: begin
                    hidx <= hidx + 3'd1;
                    if (hidx == 3'(HDR_WORDS - 1))
                        state <= (remain == '0) ? TX_TAIL : TX_PAY;
                end
                TX_PAY: if (hs) begin
                    remain <= remain - LEN_W'(1);
                    if (have_lo) begin
                        have_lo <= 1'b0;
                        if (remain == LEN_W'(1)) state <= TX_TAIL;
                    end else if (remain == LEN_W'(1)) begin
                        state <= TX_IDLE;
                    end else begin
                        lo_q    <= byte_in;
                        have_lo <= 1'b1;
                    end
                end
                TX_TAIL: state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R1
    status_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |-> (wr_data == '0));
    // R1
    wr_even_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[0] == 1'b0));
    // R5
    done_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> wr_en);
    // R7
    ready_window_chk: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> (busy && !$past(start && state == TX_IDLE)));
endmodule

// File: rtl/pfb_rx_parse.sv
module pfb_rx_parse
    import pfb_pkg::*;
#(
    parameter int               ADDR_W   = 11,
    parameter logic [WORD_W-1:0] ERR_MASK = 16'hAC00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [7:0]        out_byte,
    output logic              out_valid,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  len
);
    rx_state_e         state;
    rx_phase_e         phase;
    logic [ADDR_W-1:0] ptr;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  words_left;
    logic [7:0]        hi_q;
    logic [CNT_W-1:0]  cnt_f;
    logic [CNT_W-1:0]  body;

    assign busy    = (state != RX_IDLE);
    assign rd_en   = (state == RX_REQ);
    assign rd_addr = ptr;
    assign cnt_f   = rd_data[CNT_W-1:0];
    assign body    = cnt_f - CNT_W'(OVERHEAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            phase      <= PH_STAT;
            ptr        <= '0;
            base       <= '0;
            words_left <= '0;
            hi_q       <= '0;
            out_byte   <= '0;
            out_valid  <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            len        <= '0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            case (state)
                RX_IDLE: if (start) begin
                    ptr   <= '0;
                    phase <= PH_STAT;
                    err   <= 1'b0;
                    len   <= '0;
                    state <= RX_REQ;
                end
                RX_REQ: state <= RX_WAIT;
                RX_WAIT: begin
                    case (phase)
                        PH_STAT: begin
                            if ((rd_data & ERR_MASK) != '0) begin
                                err   <= 1'b1;
                                done  <= 1'b1;
                                state <= RX_IDLE;
                            end else begin
                                phase <= PH_CNT;
                                ptr   <= ptr + ADDR_W'(2);
                                state <= RX_REQ;
                            end
                        end
                        PH_CNT: begin
                            if (cnt_f < CNT_W'(OVERHEAD)) begin
                                err   <= 1'b1;
                                done  <= 1'b1;
                                state <= RX_IDLE;
                            end else begin
                                base       <= body;
                                words_left <= body >> 1;
                                phase      <= ((body >> 1) == '0) ? PH_CTRL : PH_DATA;
                                ptr        <= ptr + ADDR_W'(2);
                                state      <= RX_REQ;
                            end
                        end
                        PH_DATA: begin
                            out_byte   <= rd_data[7:0];
                            out_valid  <= 1'b1;
                            hi_q       <= rd_data[15:8];
                            words_left <= words_left - CNT_W'(1);
                            if (words_left == CNT_W'(1)) phase <= PH_CTRL;
                            ptr   <= ptr + ADDR_W'(2);
                            state <= RX_HI;
                        end
                        default: begin
                            if (rd_data[ODD_BIT]) begin
                                out_byte  <= rd_data[7:0];
                                out_valid <= 1'b1;
                                len       <= base + CNT_W'(1);
                            end else begin
                                len <= base;
                            end
                            done  <= 1'b1;
                            state <= RX_IDLE;
                        end
                    endcase
                end
                RX_HI: begin
                    out_byte  <= hi_q;
                    out_valid <= 1'b1;
                    state     <= RX_REQ;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R8
    rd_even_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr[0] == 1'b0));
    // R8
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && start) |=> (rd_en && rd_addr == '0));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    err_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (!out_valid && len == '0));
endmodule

// File: rtl/pkt_frame_builder.sv
module pkt_frame_builder
    import pfb_pkg::*;
#(
    parameter int               ADDR_W   = 11,
    parameter int               LEN_W    = 11,
    parameter logic [15:0]      ERR_MASK = 16'hAC00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic [47:0]       tx_dst,
    input  logic [47:0]       tx_src,
    input  logic [15:0]       tx_type,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [7:0]        tx_byte,
    input  logic              tx_byte_valid,
    output logic              tx_byte_ready,
    output logic              tx_busy,
    output logic              tx_done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [15:0]       wr_data,
    input  logic              rx_start,
    output logic              rx_busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       rd_data,
    output logic [7:0]        rx_byte,
    output logic              rx_byte_valid,
    output logic              rx_done,
    output logic              rx_err,
    output logic [10:0]       rx_len
);
    hdr_t hdr_in;
    assign hdr_in = '{dst: tx_dst, src: tx_src, etype: tx_type};

    pfb_tx_pack #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .start      (tx_start),
        .hdr_in     (hdr_in),
        .len_in     (tx_len),
        .byte_in    (tx_byte),
        .byte_valid (tx_byte_valid),
        .byte_ready (tx_byte_ready),
        .busy       (tx_busy),
        .done       (tx_done),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    pfb_rx_parse #(.ADDR_W(ADDR_W), .ERR_MASK(ERR_MASK)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .start     (rx_start),
        .busy      (rx_busy),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_byte  (rx_byte),
        .out_valid (rx_byte_valid),
        .done      (rx_done),
        .err       (rx_err),
        .len       (rx_len)
    );
endmodule

// File: tb/sim_pkt_frame_builder.sv
module sim_pkt_frame_builder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_start = 1'b0;
    logic [47:0] tx_dst = '0;
    logic [47:0] tx_src = '0;
    logic [15:0] tx_type = '0;
    logic [10:0] tx_len = '0;
    logic [7:0]  tx_byte = '0;
    logic        tx_byte_valid = 1'b0;
    logic        tx_byte_ready, tx_busy, tx_done, wr_en;
    logic [10:0] wr_addr;
    logic [15:0] wr_data;
    logic        rx_start = 1'b0;
    logic        rx_busy, rd_en;
    logic [10:0] rd_addr;
    logic [15:0] rd_data = '0;
    logic [7:0]  rx_byte;
    logic        rx_byte_valid, rx_done, rx_err;
    logic [10:0] rx_len;

    always #5 clk = ~clk;

    pkt_frame_builder u0 (.*);

    logic [15:0] mem [0:63];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[6:1]];

    int checks = 0;
    int errors = 0;
    int tx_done_cnt = 0;
    int rx_done_cnt = 0;
    logic [26:0] wq[$];
    logic [7:0]  rq[$];
    logic [10:0] exp_len;
    logic        exp_err;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string wtag(input logic [10:0] a);
        if (a == 0) return "R1";
        if (a == 2) return "R2";
        if (a <= 16) return "R3";
        return "R4/R5";
    endfunction

    function automatic logic [7:0] pb(input int seed, input int i);
        return 8'(seed * 7 + i * 13 + 1);
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                if (wq.size() == 0) begin
                    chk(0, "R1", "unexpected write", {5'd0, wr_addr, wr_data}, 0);
                end else begin
                    logic [26:0] e;
                    e = wq.pop_front();
                    chk({wr_addr, wr_data} == e, wtag(e[26:16]), "write addr/data",
                        {5'd0, wr_addr, wr_data}, {5'd0, e});
                end
            end
            if (tx_done) begin
                tx_done_cnt++;
                chk(wq.size() == 0, "R5", "done with writes pending", wq.size(), 0);
            end
            if (rx_byte_valid) begin
                if (rq.size() == 0) begin
                    chk(0, "R9", "unexpected rx byte", rx_byte, 0);
                end else begin
                    logic [7:0] eb;
                    eb = rq.pop_front();
                    chk(rx_byte == eb, "R8", "rx byte", rx_byte, eb);
                end
            end
            if (rx_done) begin
                rx_done_cnt++;
                chk(rx_len == exp_len, "R9", "rx length", rx_len, exp_len);
                chk(rx_err == exp_err, "R10", "rx error flag", rx_err, exp_err);
                chk(rq.size() == 0, "R8", "rx bytes missing", rq.size(), 0);
            end
        end
    end

    task automatic tx_send(input logic [47:0] d, input logic [47:0] s, input logic [15:0] t,
                           input int len, input int seed, input bit gaps, input bit poke);
        logic [7:0] hb [0:13];
        int a, i, cyc, n0, cnt;
        bit hs;
        for (int k = 0; k < 6; k++) begin
            hb[k]     = d[47 - 8*k -: 8];
            hb[k + 6] = s[47 - 8*k -: 8];
        end
        hb[12] = t[15:8];
        hb[13] = t[7:0];
        cnt = ((14 + len + 1) & ~1) + 6;
        wq.push_back({11'd0, 16'h0000});
        wq.push_back({11'd2, 16'(cnt)});
        for (int w = 0; w < 7; w++) wq.push_back({11'(4 + 2*w), hb[2*w+1], hb[2*w]});
        a = 18;
        for (int k = 0; k + 1 < len; k += 2) begin
            wq.push_back({11'(a), pb(seed, k + 1), pb(seed, k)});
            a += 2;
        end
        if (len % 2 == 1) wq.push_back({11'(a), 8'h20, pb(seed, len - 1)});
        else              wq.push_back({11'(a), 16'h0000});
        n0 = tx_done_cnt;
        @(negedge clk);
        tx_dst = d; tx_src = s; tx_type = t; tx_len = 11'(len); tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        // R7: header phase does not take bytes
        chk(tx_byte_ready == 1'b0, "R7", "ready during status write", tx_byte_ready, 0);
        i = 0; cyc = 0;
        while (i < len) begin
            tx_byte_valid = !(gaps && (cyc % 3 == 1));
            tx_byte       = pb(seed, i);
            tx_start      = poke && (cyc == 2 || cyc == 9); // R6 stray start
            hs = tx_byte_valid && tx_byte_ready;
            @(posedge clk);
            if (hs) i++;
            @(negedge clk);
            cyc++;
        end
        tx_byte_valid = 1'b0;
        tx_start      = 1'b0;
        for (int k = 0; k < 60 && tx_done_cnt == n0; k++) @(negedge clk);
        chk(tx_done_cnt == n0 + 1, "R5", "tx_done count", tx_done_cnt - n0, 1);
        chk(tx_busy == 1'b0, "R6", "busy after packet", tx_busy, 0);
    endtask

    task automatic rx_run;
        int n0;
        n0 = rx_done_cnt;
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        for (int k = 0; k < 600 && rx_done_cnt == n0; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(rx_done_cnt == n0 + 1, "R12", "rx_done pulses", rx_done_cnt - n0, 1);
    endtask

    task automatic rx_good(input int flen, input int seed, input logic [15:0] stat,
                           input logic [4:0] junk);
        int ev, w;
        ev = flen & ~1;
        mem[0] = stat;
        mem[1] = {junk, 11'(ev + 6)};
        for (w = 0; w < ev / 2; w++) begin
            mem[2 + w] = {pb(seed, 2*w + 1), pb(seed, 2*w)};
            rq.push_back(pb(seed, 2*w));
            rq.push_back(pb(seed, 2*w + 1));
        end
        if (flen % 2 == 1) begin
            mem[2 + w] = {8'h20, pb(seed, flen - 1)};
            rq.push_back(pb(seed, flen - 1));
        end else begin
            mem[2 + w] = {8'h00, 8'hA5};
        end
        exp_len = 11'(flen);
        exp_err = 1'b0;
        rx_run();
    endtask

    task automatic rx_bad(input logic [15:0] stat, input logic [15:0] cnt);
        mem[0] = stat;
        mem[1] = cnt;
        mem[2] = 16'h1234;
        exp_len = '0;
        exp_err = 1'b1;
        rx_run();
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R13", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(!wr_en && !rd_en, "R13", "strobes after reset", {wr_en, rd_en}, 0);
        chk(!tx_busy && !rx_busy, "R13", "busy after reset", {tx_busy, rx_busy}, 0);
        chk(!tx_done && !rx_done && !rx_byte_valid && !tx_byte_ready, "R13", "pulses after reset",
            {tx_done, rx_done, rx_byte_valid, tx_byte_ready}, 0);

        // Transmit: R1..R7
        tx_send(48'h0A1B2C3D4E5F, 48'h112233445566, 16'h0800, 10, 1, 0, 0); // even
        tx_send(48'hFFFFFFFFFFFF, 48'h0200DEADBEEF, 16'h86DD, 7, 2, 0, 0);  // odd
        tx_send(48'h010203040506, 48'h0708090A0B0C, 16'h1234, 0, 3, 0, 0);  // empty
        tx_send(48'hA0A1A2A3A4A5, 48'hB0B1B2B3B4B5, 16'hABCD, 1, 4, 0, 0);  // single
        tx_send(48'h665544332211, 48'hCAFEF00D0001, 16'h0806, 21, 5, 1, 1); // stalls, stray start
        tx_send(48'h123456789ABC, 48'h0F0E0D0C0B0A, 16'h88CC, 16, 6, 1, 0);

        // Receive: R8..R12
        rx_good(14, 7, 16'h0000, 5'h00);
        rx_good(17, 8, 16'h0000, 5'h1F);   // odd marker, upper count bits ignored
        rx_good(30, 9, 16'h0010, 5'h00);   // non-masked status bit ignored
        rx_good(0, 10, 16'h0000, 5'h00);
        rx_good(1, 11, 16'h0000, 5'h00);
        rx_bad(16'h8000, 16'd20);          // R10 masked error
        rx_bad(16'h0400, 16'd20);          // R10
        rx_bad(16'h0000, 16'd4);           // R11 short count
        rx_good(41, 12, 16'h0000, 5'h00);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule